// File: doc/BRIEF.md
# Beat-Period Trigger Sequencer

This block watches a digitized triangle wave produced by a phase detector that compares two RF signals of nearly equal frequency. Each sample is classified against a programmable zero level to give a polarity bit, and successive samples are compared to give a slope bit. The slope bit ignores short reversals near the peaks. Each change of slope produces a one-clock up or down pulse. The clocks between consecutive zero crossings are counted. That count grows as the beat frequency falls. The first time the count exceeds a programmed threshold, the block starts a fixed start-up sequence.

The sequence runs in this order: a one-clock frequency trigger, a hold level at the next rising zero crossing, release of the divide counters at the next falling slope pulse, then a run level after a programmed delay. The block also keeps two results for the downstream trajectory timing. The first is the count excess at the trigger. The second is a flag that says whether a rising slope pulse came before the release. The flag calls for a slower reference trajectory. A synchronous clear takes the sequence back to idle and rearms the trigger.

Top module: `beat_trig_seq`

## Requirements
- R1: `polarity` shows, one clock after a sample is presented, whether that sample is strictly greater than `zc_level` (1 = above). A change of `polarity` is a zero crossing: 0 to 1 is a rising crossing and 1 to 0 is a falling crossing.
- R2: `slope` changes state only after SLOPE_K consecutive samples (default 3) each move against it. Rising against `slope`=0 means each sample is greater than the one before it. Falling against `slope`=1 means each sample is less than the one before it. A sample equal to, or moving with, the current direction restarts the run. At the clock where `slope` changes, `up_pulse` (for 0 to 1) or `dn_pulse` (for 1 to 0) is high for exactly one cycle. The two pulses are never high together. `slope` is 0 after reset.
- R3: The crossing period is the number of clocks from one zero crossing to the next. The count saturates at 2^CNT_W-1 and does not wrap. The first crossing after reset gives no period.
- R4: `freq_trig` pulses high for one cycle, in the cycle after `polarity` changes, when the period ending at that crossing is strictly greater than `period_thresh`. It pulses only while the sequencer is idle, so it fires once until the next clear.
- R5: `trig_delta` takes the signed value (period minus `period_thresh`) in the same cycle as `freq_trig`, and keeps it until the next trigger.
- R6: `hold` rises one cycle after the first rising crossing whose `polarity` 0-to-1 change comes after the cycle in which `freq_trig` is high. It stays high until clear.
- R7: `alt_slope` is set when `up_pulse` is high in any cycle from the `freq_trig` cycle up to the release. It stays set until clear.
- R8: `load_cnt` is 1 while idle. It goes to 0 one cycle after the first `dn_pulse` seen while `hold` is high, and stays 0 until clear.
- R9: `run` rises `run_delay`+1 cycles after the cycle of that releasing `dn_pulse`. With `run_delay`=0 it rises with the release. It stays high until clear.
- R10: `clear` is synchronous and takes priority over a trigger in the same cycle. One cycle after it, `hold`=0, `load_cnt`=1, `alt_slope`=0 and `run`=0, and the next qualifying crossing triggers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous return to idle and rearm |
| sample | input | SAMPLE_W | Phase-detector sample, one per clock |
| zc_level | input | SAMPLE_W | Zero-crossing level (midpoint 0x2000) |
| period_thresh | input | CNT_W | Crossing-period threshold in clocks |
| run_delay | input | DLY_W | Clocks from release to run |
| polarity | output | 1 | Sample above zero level |
| slope | output | 1 | Filtered direction, 1 = rising |
| up_pulse | output | 1 | One-cycle pulse when slope turns rising |
| dn_pulse | output | 1 | One-cycle pulse when slope turns falling |
| freq_trig | output | 1 | One-cycle frequency trigger |
| hold | output | 1 | Hold level after trigger |
| load_cnt | output | 1 | 1 keeps divide counters loaded, 0 releases them |
| alt_slope | output | 1 | Use the slower trajectory |
| run | output | 1 | Trajectory start level |
| trig_delta | output | CNT_W+1 | Signed period excess at trigger |

## Verification
Each result is due at a fixed latency after a stimulus:
- `polarity`, `slope` and the slope pulses come one clock after the sample.
- `freq_trig` and `trig_delta` come two clocks after the sample that crosses the level.
- `hold` comes one clock after `polarity` rises.
- `load_cnt` comes one clock after the releasing `dn_pulse`.
- `run` comes `run_delay`+1 clocks after that pulse.

The bench drives a new sample on each falling edge. It advances its own model of these requirements just after each rising edge and compares every output at the next falling edge, so each result is checked in exactly the cycle in which it is due.

// File: rtl/beat_trig_pkg.sv
package beat_trig_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WAIT_HOLD,
    SEQ_WAIT_REL,
    SEQ_DELAY,
    SEQ_RUN
  } seq_state_t;

  // Direction of a new sample relative to the previous one: +1, -1 or 0.
  function automatic int step_dir(input int unsigned now_v, input int unsigned prev_v);
    if (now_v > prev_v) return 1;
    if (now_v < prev_v) return -1;
    return 0;
  endfunction

endpackage

// File: rtl/beat_edge_detect.sv
module beat_edge_detect #(
  parameter int SAMPLE_W = 14,
  parameter int SLOPE_K  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] zc_level,
  output logic                polarity,
  output logic                slope,
  output logic                up_pulse,
  output logic                dn_pulse,
  output logic                zc_up,
  output logic                zc_dn
);
  import beat_trig_pkg::*;

  localparam int RW = (SLOPE_K > 1) ? $clog2(SLOPE_K) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(SLOPE_K - 1);

  logic [SAMPLE_W-1:0] s_prev;
  logic [RW-1:0]       run_len;
  logic                pol_next;
  logic                against;
  int                  dir;

  always_comb begin
    pol_next = (sample > zc_level);
    dir      = step_dir(int'(sample), int'(s_prev));
    against  = slope ? (dir < 0) : (dir > 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polarity <= 1'b0;
      zc_up    <= 1'b0;
      zc_dn    <= 1'b0;
      s_prev   <= '0;
      slope    <= 1'b0;
      run_len  <= '0;
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
    end else begin
      polarity <= pol_next;
      zc_up    <= pol_next & ~polarity;
      zc_dn    <= ~pol_next & polarity;
      s_prev   <= sample;
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
      if (against) begin
        if (run_len == RUN_LAST) begin
          slope   <= ~slope;
          run_len <= '0;
          if (slope) dn_pulse <= 1'b1;
          else       up_pulse <= 1'b1;
        end else begin
          run_len <= run_len + 1'b1;
        end
      end else begin
        run_len <= '0;
      end
    end
  end

  // R2: the two slope pulses are exclusive
  p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_pulse && dn_pulse));

  // R1: a zero-crossing event always coincides with a polarity change
  p_zc_tracks_pol_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_up || zc_dn) |-> (polarity != $past(polarity)));

endmodule

// File: rtl/beat_period_count.sv
module beat_period_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_evt,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] period,
  output logic             over_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic seen;

  assign over_evt = zc_evt && seen && (period > thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
      seen   <= 1'b0;
    end else if (zc_evt) begin
      period <= CNT_W'(1);
      seen   <= 1'b1;
    end else if (period != CNT_MAX) begin
      period <= period + 1'b1;
    end
  end

  // R3: saturated count stays put until a crossing
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (period == CNT_MAX && !zc_evt) |=> (period == CNT_MAX));

endmodule

// File: rtl/beat_start_seq.sv
module beat_start_seq #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    over_evt,
  input  logic [CNT_W-1:0]        period,
  input  logic [CNT_W-1:0]        thresh,
  input  logic                    zc_up,
  input  logic                    up_pulse,
  input  logic                    dn_pulse,
  input  logic [DLY_W-1:0]        run_delay,
  output logic                    freq_trig,
  output logic                    hold,
  output logic                    load_cnt,
  output logic                    alt_slope,
  output logic                    run,
  output logic signed [CNT_W:0]   trig_delta
);
  import beat_trig_pkg::*;

  seq_state_t       state;
  logic [DLY_W-1:0] dcnt;

  function automatic logic signed [CNT_W:0] excess_of(input logic [CNT_W-1:0] c,
                                                      input logic [CNT_W-1:0] t);
    return $signed({1'b0, c}) - $signed({1'b0, t});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      freq_trig  <= 1'b0;
      hold       <= 1'b0;
      load_cnt   <= 1'b1;
      alt_slope  <= 1'b0;
      run        <= 1'b0;
      dcnt       <= '0;
      trig_delta <= '0;
    end else begin
      freq_trig <= 1'b0;
      if (clear) begin
        state     <= SEQ_IDLE;
        hold      <= 1'b0;
        load_cnt  <= 1'b1;
        alt_slope <= 1'b0;
        run       <= 1'b0;
      end else begin
        case (state)
          SEQ_IDLE: begin
            if (over_evt) begin
              freq_trig  <= 1'b1;
              trig_delta <= excess_of(period, thresh);
              state      <= SEQ_WAIT_HOLD;
            end
          end
          SEQ_WAIT_HOLD: begin
            if (up_pulse) alt_slope <= 1'b1;
            if (zc_up) begin
              hold  <= 1'b1;
              state <= SEQ_WAIT_REL;
            end
          end
          SEQ_WAIT_REL: begin
            if (up_pulse) alt_slope <= 1'b1;
            if (dn_pulse) begin
              load_cnt <= 1'b0;
              if (run_delay == '0) begin
                run   <= 1'b1;
                state <= SEQ_RUN;
              end else begin
                dcnt  <= run_delay;
                state <= SEQ_DELAY;
              end
            end
          end
          SEQ_DELAY: begin
            if (dcnt == DLY_W'(1)) begin
              run   <= 1'b1;
              state <= SEQ_RUN;
            end else begin
              dcnt <= dcnt - 1'b1;
            end
          end
          SEQ_RUN: ;
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  // R4: trigger is a single-cycle pulse
  p_trig_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freq_trig |=> !freq_trig);

  // R8: counters are only released once hold is up
  p_load_needs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cnt |-> hold);

  // R9: run never precedes the release
  p_run_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !load_cnt);

endmodule

// File: rtl/beat_trig_seq.sv
module beat_trig_seq #(
  parameter int SAMPLE_W = 14,
  parameter int CNT_W    = 16,
  parameter int DLY_W    = 16,
  parameter int SLOPE_K  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic [SAMPLE_W-1:0]   sample,
  input  logic [SAMPLE_W-1:0]   zc_level,
  input  logic [CNT_W-1:0]      period_thresh,
  input  logic [DLY_W-1:0]      run_delay,
  output logic                  polarity,
  output logic                  slope,
  output logic                  up_pulse,
  output logic                  dn_pulse,
  output logic                  freq_trig,
  output logic                  hold,
  output logic                  load_cnt,
  output logic                  alt_slope,
  output logic                  run,
  output logic signed [CNT_W:0] trig_delta
);

  logic             zc_up;
  logic             zc_dn;
  logic             zc_any;
  logic             over_evt;
  logic [CNT_W-1:0] period;

  assign zc_any = zc_up | zc_dn;

  beat_edge_detect #(.SAMPLE_W(SAMPLE_W), .SLOPE_K(SLOPE_K)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (sample),
    .zc_level (zc_level),
    .polarity (polarity),
    .slope    (slope),
    .up_pulse (up_pulse),
    .dn_pulse (dn_pulse),
    .zc_up    (zc_up),
    .zc_dn    (zc_dn)
  );

  beat_period_count #(.CNT_W(CNT_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .zc_evt   (zc_any),
    .thresh   (period_thresh),
    .period   (period),
    .over_evt (over_evt)
  );

  beat_start_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .over_evt   (over_evt),
    .period     (period),
    .thresh     (period_thresh),
    .zc_up      (zc_up),
    .up_pulse   (up_pulse),
    .dn_pulse   (dn_pulse),
    .run_delay  (run_delay),
    .freq_trig  (freq_trig),
    .hold       (hold),
    .load_cnt   (load_cnt),
    .alt_slope  (alt_slope),
    .run        (run),
    .trig_delta (trig_delta)
  );

  // R4: trigger only follows a zero crossing
  p_trig_at_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freq_trig |-> $past(zc_any));

  // R6: hold rises only on a rising crossing
  p_hold_after_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(zc_up));

endmodule

// File: tb/beat_trig_seq_bench.sv
module beat_trig_seq_bench;
  localparam int SW = 14;
  localparam int CW = 16;
  localparam int DW = 16;
  localparam int K  = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic [SW-1:0] smp = '0;
  logic [SW-1:0] lvl = 14'h2000;
  logic [CW-1:0] thr = 16'h12F0;
  logic [DW-1:0] dly = '0;
  logic polarity, slope, up_pulse, dn_pulse, freq_trig, hold, load_cnt, alt_slope, run;
  logic signed [CW:0] trig_delta;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  beat_trig_seq #(.SAMPLE_W(SW), .CNT_W(CW), .DLY_W(DW), .SLOPE_K(K)) u_beat_trig_seq (
    .clk(clk), .rst_n(rst_n), .clear(clr), .sample(smp), .zc_level(lvl),
    .period_thresh(thr), .run_delay(dly), .polarity(polarity), .slope(slope),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse), .freq_trig(freq_trig), .hold(hold),
    .load_cnt(load_cnt), .alt_slope(alt_slope), .run(run), .trig_delta(trig_delta));

  // Expected-value model built from the requirements
  int e_pol, e_zu, e_zd, e_prev, e_slope, e_up, e_dn;
  int hist[K];
  int e_cnt, e_seen, e_state, e_trig, e_hold, e_load, e_alt, e_run, e_dcnt, e_delta;
  int dut_trigs, exp_trigs;

  task automatic model_reset();
    e_pol = 0; e_zu = 0; e_zd = 0; e_prev = 0; e_slope = 0; e_up = 0; e_dn = 0;
    for (int i = 0; i < K; i++) hist[i] = 0;
    e_cnt = 0; e_seen = 0; e_state = 0; e_trig = 0; e_hold = 0; e_load = 1;
    e_alt = 0; e_run = 0; e_dcnt = 0; e_delta = 0;
  endtask

  task automatic model_step();
    int over, p, d, all_opp, want;
    over = ((e_zu | e_zd) != 0 && e_seen != 0 && e_cnt > int'(thr)) ? 1 : 0;
    e_trig = 0;
    if (clr) begin
      e_state = 0; e_hold = 0; e_load = 1; e_alt = 0; e_run = 0;
    end else begin
      case (e_state)
        0: if (over != 0) begin e_trig = 1; e_delta = e_cnt - int'(thr); e_state = 1; end
        1: begin if (e_up != 0) e_alt = 1; if (e_zu != 0) begin e_hold = 1; e_state = 2; end end
        2: begin
          if (e_up != 0) e_alt = 1;
          if (e_dn != 0) begin
            e_load = 0;
            if (dly == 0) begin e_run = 1; e_state = 4; end
            else begin e_dcnt = int'(dly); e_state = 3; end
          end
        end
        3: if (e_dcnt == 1) begin e_run = 1; e_state = 4; end else e_dcnt--;
        default: ;
      endcase
    end
    if ((e_zu | e_zd) != 0) begin e_cnt = 1; e_seen = 1; end
    else if (e_cnt < CMAX) e_cnt++;
    p = (int'(smp) > int'(lvl)) ? 1 : 0;
    e_zu = (p == 1 && e_pol == 0) ? 1 : 0;
    e_zd = (p == 0 && e_pol == 1) ? 1 : 0;
    e_pol = p;
    d = (int'(smp) > e_prev) ? 1 : ((int'(smp) < e_prev) ? -1 : 0);
    for (int i = K - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = d;
    e_prev = int'(smp);
    want = (e_slope != 0) ? -1 : 1;
    all_opp = 1;
    for (int i = 0; i < K; i++) if (hist[i] != want) all_opp = 0;
    e_up = 0; e_dn = 0;
    if (all_opp != 0) begin
      if (e_slope != 0) e_dn = 1; else e_up = 1;
      e_slope = 1 - e_slope;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 polarity", int'(polarity), e_pol);
    chk("R2 slope", int'(slope), e_slope);
    chk("R2 up_pulse", int'(up_pulse), e_up);
    chk("R2 dn_pulse", int'(dn_pulse), e_dn);
    chk("R4 freq_trig", int'(freq_trig), e_trig);
    chk("R5 trig_delta", int'(trig_delta), e_delta);
    chk("R6 hold", int'(hold), e_hold);
    chk("R7 alt_slope", int'(alt_slope), e_alt);
    chk("R8 load_cnt", int'(load_cnt), e_load);
    chk("R9 run", int'(run), e_run);
  endtask

  task automatic tick(input int v);
    int c;
    c = (v < 0) ? 0 : ((v > (1 << SW) - 1) ? (1 << SW) - 1 : v);
    smp = SW'(c);
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (freq_trig) dut_trigs++;
    if (e_trig != 0) exp_trigs++;
    compare_all();
  endtask

  task automatic pulse_clear();
    clr = 1'b1;
    tick(int'(smp));
    clr = 1'b0;
    chk("R10 hold after clear", int'(hold), 0);
    chk("R10 load_cnt after clear", int'(load_cnt), 1);
    chk("R10 run after clear", int'(run), 0);
    chk("R10 alt after clear", int'(alt_slope), 0);
  endtask

  // Triangle with rise/fall halves growing in length; optional peak jitter and mid-run clear
  task automatic scenario(input int level, input int th, input int dl, input int step,
                          input bit jit, input int clear_at);
    int v, dir, half, n;
    lvl = SW'(level); thr = CW'(th); dly = DW'(dl);
    pulse_clear();
    v = level - 4 * step; dir = 1; half = 8; n = 0;
    tick(v);
    while (half <= th + 14) begin
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < half; i++) begin
          if (jit && i == 1) v = v - dir * (step / 2);
          else v = v + dir * step;
          if (n == clear_at) begin clr = 1'b1; tick(v); clr = 1'b0; end
          else tick(v);
          n++;
        end
        dir = -dir;
      end
      half = half + 3;
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // reset state (R1, R2, R4, R8, R9)
    chk("R1 reset polarity", int'(polarity), 0);
    chk("R2 reset slope", int'(slope), 0);
    chk("R4 reset freq_trig", int'(freq_trig), 0);
    chk("R6 reset hold", int'(hold), 0);
    chk("R8 reset load_cnt", int'(load_cnt), 1);
    chk("R9 reset run", int'(run), 0);
    rst_n = 1'b1;

    scenario(14'h2000, 30, 0, 40, 1'b0, -1);
    scenario(14'h2000, 33, 1, 40, 1'b1, -1);
    scenario(14'h2400, 45, 7, 30, 1'b1, -1);
    scenario(14'h1C00, 26, 3, 50, 1'b0, -1);
    scenario(14'h2000, 20, 2, 40, 1'b1, 400);   // R10: clear mid-sequence then rearm
    scenario(14'h2000, 40, 0, 40, 1'b1, -1);
    chk("R4 trigger count", dut_trigs, exp_trigs);

    // R3/R5: saturated period yields excess of 1 against threshold 2^CW-2
    lvl = 14'h2000; thr = CW'(CMAX - 1); dly = DW'(2);
    pulse_clear();
    dut_trigs = 0;
    repeat (5) tick(int'(lvl) - 100);
    repeat (CMAX + 500) tick(int'(lvl) + 100);
    repeat (4) tick(int'(lvl) - 100);
    chk("R3 saturated period triggers", dut_trigs, 1);
    chk("R5 delta at saturation", int'(trig_delta), 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule